// File: doc/BRIEF.md
# Hash Input Word Ingest and Byte Reorder

This block is the front end of a message-digest engine. Software or a DMA engine writes the message as 32-bit words into a write-only data port. The port has no byte-valid mask. The block permutes the four byte lanes of each word according to a 2-bit order code, and tracks how many message bytes remain out of a programmed length given in bits. It then passes each word to the hash core together with a count of the bytes in it that belong to the message. The word that completes the message is tagged as the last one, and any bytes past the message end are cleared to zero.

Configuration arrives as plain inputs. A one-cycle `cfg_wr` strobe latches the order code and the message length, and starts a new message. A data word is refused with a one-cycle `wr_err` pulse, and never reaches the core, in two cases: no configuration has been strobed since reset, or the programmed length has already been consumed. A two-entry skid buffer separates the data port from the core's valid/ready handshake. With the core always ready, the port takes one word per clock without stalling.

Top module: `hash_word_ingest`

## Requirements
- R1: While reset is applied, `out_valid` and `wr_err` are 0 and `in_ready` is 1.
- R2: The order code sets the output word `r` from the input byte lanes `b3..b0` (b0 = bits 7:0). Code 0 gives r = {b3,b2,b1,b0}, code 1 gives r = {b0,b1,b2,b3}, code 2 gives r = {b2,b3,b1,b0}, and code 3 gives r = {b1,b0,b3,b2}. Message bytes fill `r` from bits 7:0 upward.
- R3: Every accepted word other than the last word of a message is output with `out_nbytes` = 4 and `out_last` = 0.
- R4: The message holds `cfg_len_bits >> 3` bytes, so the low three length bits are ignored. The word that completes the message carries the remaining count of 1 to 4 bytes in `out_nbytes`, with `out_last` = 1.
- R5: The output byte lanes at and above `out_nbytes` are driven as zero.
- R6: A word handshaken before the first `cfg_wr` since reset produces no output. It raises `wr_err` for exactly one cycle, in the cycle after the handshake.
- R7: A word handshaken after the programmed byte count has been consumed produces no output and raises `wr_err` for one cycle, in the cycle after the handshake.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word, byte count and last flag hold steady into the next cycle.
- R9: `in_ready` is 0 only while the skid buffer holds two words. With `out_ready` held at 1, a burst of four back-to-back words is taken without a stall.
- R10: Each `cfg_wr` starts a new message. Byte accounting restarts from zero with the newly latched length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cfg_wr | input | 1 | One-cycle strobe that latches the order code and length and starts a message |
| cfg_order | input | 2 | Byte-order code |
| cfg_len_bits | input | LEN_W | Message length in bits |
| in_valid | input | 1 | A data word is offered |
| in_data | input | 32 | Data word |
| in_ready | output | 1 | The port can take a word this cycle |
| out_valid | output | 1 | A word is offered to the hash core |
| out_data | output | 32 | Reordered word with the padding lanes cleared |
| out_nbytes | output | 3 | Number of message bytes in `out_data`, 1 to 4 |
| out_last | output | 1 | This word completes the message |
| out_ready | input | 1 | The hash core takes the word |
| wr_err | output | 1 | One-cycle pulse for a refused data word |

## Verification
The embedded properties assume that `cfg_wr` is strobed only when no data word is offered in the same cycle and the skid buffer has drained. They also assume that the length and order inputs matter only in the strobe cycle. The bench drives the data port and the strobe from separate tasks, and waits for every expected word to leave before it reconfigures, so it never breaks these assumptions. Its sweep covers all four order codes, message lengths from 0 to 12 bytes with the low bits clear or set, and several core-ready patterns that include long back-pressure.

// File: rtl/hin_pkg.sv
package hin_pkg;

  localparam int LANES = 4;
  localparam int WORD_W = 8 * LANES;
  localparam int NB_W = 3;

  typedef enum logic [1:0] {
    ORD_STRAIGHT = 2'd0,
    ORD_REVERSED = 2'd1,
    ORD_HI_SWAP  = 2'd2,
    ORD_HALF_ROT = 2'd3
  } order_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [NB_W-1:0]   nbytes;
    logic              last;
  } hin_entry_t;

  // Source lane feeding output lane `lane` for a given order code.
  function automatic logic [1:0] lane_src(input logic [1:0] code, input logic [1:0] lane);
    logic [1:0] s;
    case (order_e'(code))
      ORD_STRAIGHT: s = lane;
      ORD_REVERSED: s = ~lane;
      ORD_HI_SWAP:  s = lane[1] ? {lane[1], ~lane[0]} : lane;
      default:      s = lane ^ 2'b10;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hin_lane_mux.sv
module hin_lane_mux
  import hin_pkg::*;
(
  input  logic [1:0]        code,
  input  logic [NB_W-1:0]   nbytes,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [1:0] LN = 2'(i);
    logic [1:0] src;
    logic       keep;
    always_comb begin
      src  = lane_src(code, LN);
      keep = (NB_W'(i) < nbytes);
    end
    assign dout[8*i +: 8] = keep ? din[8*src +: 8] : 8'h00;
  end

endmodule

// File: rtl/hin_msg_track.sv
module hin_msg_track
  import hin_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             word_hs,
  output logic             take,
  output logic [NB_W-1:0]  nbytes,
  output logic             last,
  output logic             wr_err
);

  localparam int CW = LEN_W - 3;

  logic          seen_q, seen_d;
  logic [CW-1:0] tgt_q, tgt_d;
  logic [CW-1:0] acc_q, acc_d;
  logic [CW-1:0] rem;
  logic          done;
  logic          upd_en;
  logic          err_q, err_d;
  logic          unused_lowbits;

  assign unused_lowbits = ^cfg_len_bits[2:0];

  always_comb begin
    rem    = tgt_q - acc_q;
    done   = (rem == '0);
    take   = word_hs & seen_q & ~done & ~cfg_wr;
    nbytes = (rem >= CW'(4)) ? NB_W'(4) : rem[NB_W-1:0];
    last   = (rem <= CW'(4));
    err_d  = word_hs & ~take;
  end

  always_comb begin
    seen_d = seen_q;
    tgt_d  = tgt_q;
    acc_d  = acc_q;
    upd_en = cfg_wr | take;
    if (cfg_wr) begin
      seen_d = 1'b1;
      tgt_d  = cfg_len_bits[LEN_W-1:3];
      acc_d  = '0;
    end else if (take) begin
      acc_d = acc_q + CW'(nbytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      tgt_q  <= '0;
      acc_q  <= '0;
    end else if (upd_en) begin
      seen_q <= seen_d;
      tgt_q  <= tgt_d;
      acc_q  <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign wr_err = err_q;

  AST_ACC_WITHIN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= tgt_q); // R7
  AST_ERR_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (word_hs && !seen_q) |=> wr_err); // R6
  AST_COUNT_FROZEN_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wr) |=> $stable(acc_q)); // R7

endmodule

// File: rtl/hin_skid.sv
module hin_skid #(
  parameter int W     = 36,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push & ~full;
    do_pop  = pop & ~empty;
    wp_d    = do_push ? ptr_inc(wp_q) : wp_q;
    rp_d    = do_pop ? ptr_inc(rp_q) : rp_q;
    cnt_d   = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = do_push && (wp_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wen) mem_q[i] <= din;
    end
  end

  assign dout = mem_q[rp_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_FILL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R9

endmodule

// File: rtl/hash_word_ingest.sv
module hash_word_ingest
  import hin_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_order,
  input  logic [LEN_W-1:0]  cfg_len_bits,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [NB_W-1:0]   out_nbytes,
  output logic              out_last,
  input  logic              out_ready,
  output logic              wr_err
);

  localparam int ENTRY_W = $bits(hin_entry_t);

  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic [1:0]        order_q;
  logic              word_hs;
  logic              take;
  logic [NB_W-1:0]   nbytes;
  logic              last;
  logic [WORD_W-1:0] shaped;
  hin_entry_t        push_e, head_e;
  logic              full, empty;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    order_q <= 2'd0;
    else if (cfg_wr) order_q <= cfg_order;
  end

  assign word_hs = in_valid & in_ready;

  hin_msg_track #(.LEN_W(LEN_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .cfg_wr       (cfg_wr),
    .cfg_len_bits (cfg_len_bits),
    .word_hs      (word_hs),
    .take         (take),
    .nbytes       (nbytes),
    .last         (last),
    .wr_err       (wr_err)
  );

  hin_lane_mux u_lane (
    .code   (order_q),
    .nbytes (nbytes),
    .din    (in_data),
    .dout   (shaped)
  );

  always_comb begin
    push_e.data   = shaped;
    push_e.nbytes = nbytes;
    push_e.last   = last;
  end

  hin_skid #(.W(ENTRY_W), .DEPTH(DEPTH)) u_skid (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (take),
    .din   (push_e),
    .pop   (out_valid & out_ready),
    .dout  (head_e),
    .full  (full),
    .empty (empty)
  );

  assign in_ready   = ~full;
  assign out_valid  = ~empty;
  assign out_data   = head_e.data;
  assign out_nbytes = head_e.nbytes;
  assign out_last   = head_e.last;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_nbytes) && $stable(out_last))); // R8
  AST_NONLAST_FULL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_last) |-> (out_nbytes == NB_W'(4))); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> ((out_data >> {out_nbytes, 3'b000}) == '0)); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> (out_nbytes != '0 && out_nbytes <= NB_W'(4))); // R4

endmodule

// File: tb/tb_hash_word_ingest.sv
`timescale 1ns/1ps
module tb_hash_word_ingest;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_order = 2'd0;
  logic [31:0] cfg_len_bits = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic [2:0]  out_nbytes;
  logic        out_last;
  logic        out_ready = 1'b0;
  logic        wr_err;

  always #2.5 clk = ~clk;

  hash_word_ingest dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_order(cfg_order),
    .cfg_len_bits(cfg_len_bits), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_nbytes(out_nbytes), .out_last(out_last), .out_ready(out_ready),
    .wr_err(wr_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done_all = 1'b0;
  int rmode = 0;

  // bench model of the message
  bit b_cfg = 1'b0;
  int b_target = 0;
  int b_acc = 0;
  int b_order = 0;

  logic [31:0] e_data [0:255];
  int          e_nb   [0:255];
  bit          e_last [0:255];
  int wr_i = 0;
  int rd_i = 0;

  bit exp_err_next = 1'b0;
  bit exp_err_q = 1'b0;
  bit hold_pend = 1'b0;
  logic [31:0] hold_data;
  int hold_nb;
  bit hold_last;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 lane permutation followed by R5 masking
  function automatic logic [31:0] model_word(input int code, input logic [31:0] w, input int nb);
    logic [7:0] b0, b1, b2, b3;
    logic [31:0] r;
    b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
    case (code)
      0: r = {b3, b2, b1, b0};
      1: r = {b0, b1, b2, b3};
      2: r = {b2, b3, b1, b0};
      default: r = {b1, b0, b3, b2};
    endcase
    for (int k = 0; k < 4; k++) if (k >= nb) r[8*k +: 8] = 8'h00;
    return r;
  endfunction

  always @(posedge clk) exp_err_q <= exp_err_next;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_all) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (mon_on) begin
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = cyc[0];
        2: out_ready = (cyc % 3) != 0;
        default: out_ready = 1'b0;
      endcase
      if (hold_pend) begin
        check(out_valid && out_data == hold_data && int'(out_nbytes) == hold_nb &&
              out_last == hold_last, "R8 hold", out_data, hold_data);
      end
      hold_pend = out_valid && !out_ready;
      hold_data = out_data; hold_nb = int'(out_nbytes); hold_last = out_last;
      if (out_valid && out_ready) begin
        if (rd_i == wr_i) begin
          check(1'b0, "R6 R7 unexpected word", out_data, 0);
        end else begin
          check(out_data == e_data[rd_i], "R2 R5 data", out_data, e_data[rd_i]);
          check(int'(out_nbytes) == e_nb[rd_i], "R3 R4 nbytes", out_nbytes, e_nb[rd_i]);
          check(out_last == e_last[rd_i], "R4 last", out_last, e_last[rd_i]);
          rd_i++;
        end
      end
      if (exp_err_q || wr_err) check(wr_err == exp_err_q, "R6 R7 wr_err", wr_err, exp_err_q);
    end
  end

  task automatic configure(input int code, input int len_bits);
    @(negedge clk);
    in_valid = 1'b0; exp_err_next = 1'b0;
    cfg_wr = 1'b1; cfg_order = 2'(code); cfg_len_bits = 32'(len_bits);
    b_cfg = 1'b1; b_target = len_bits / 8; b_acc = 0; b_order = code;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] d, output int tries);
    bit err;
    bit hs;
    int rem;
    int nb;
    err = !b_cfg || (b_acc == b_target);
    if (!err) begin
      rem = b_target - b_acc;
      nb = (rem >= 4) ? 4 : rem;
      e_data[wr_i] = model_word(b_order, d, nb);
      e_nb[wr_i] = nb;
      e_last[wr_i] = (rem <= 4);
      wr_i++;
      b_acc += nb;
    end
    tries = 0;
    forever begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d;
      hs = in_ready;
      exp_err_next = hs && err;
      tries++;
      @(posedge clk);
      if (hs) break;
    end
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0; exp_err_next = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((rd_i != wr_i || out_valid) && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    check(rd_i == wr_i, tag, rd_i, wr_i);
    wr_i = 0; rd_i = 0;
  endtask

  initial begin
    int tries;
    int stalls;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(wr_err == 1'b0, "R1 wr_err", wr_err, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;

    // R6: data before any configuration
    rmode = 0;
    send_word(32'hA1B2C3D4, tries);
    send_word(32'h01020304, tries);
    stop_in();
    drain("R6 no output");

    // R2 R3 R4 R5 R7 sweep: every order, lengths 0..12 bytes, low bits clear or set
    for (int o = 0; o < 4; o++) begin
      for (int nb = 0; nb <= 12; nb++) begin
        for (int lb = 0; lb < 2; lb++) begin
          int nw;
          rmode = (o + nb + lb) % 3;
          configure(o, nb * 8 + lb * 5);
          nw = (nb + 3) / 4;
          for (int w = 0; w <= nw; w++) begin   // the extra word must be refused (R7)
            logic [7:0] s;
            s = 8'(o * 64 + nb * 4 + w * 16 + lb);
            send_word({s + 8'd3, s + 8'd2, s + 8'd1, s}, tries);
          end
          stop_in();
          drain("R4 sweep drain");
        end
      end
    end

    // R10: reconfiguring mid-message restarts the byte count and the order
    rmode = 0;
    configure(1, 96);
    send_word(32'h11223344, tries);
    stop_in();
    drain("R10 first");
    configure(2, 40);
    send_word(32'h55667788, tries);
    send_word(32'h99AABBCC, tries);
    send_word(32'hDDEEFF00, tries);
    stop_in();
    drain("R10 second");

    // R9: four-word burst with the core always ready
    rmode = 0;
    configure(0, 128);
    stalls = 0;
    for (int w = 0; w < 4; w++) begin
      send_word(32'hC0DE0000 + 32'(w), tries);
      stalls += tries - 1;
    end
    stop_in();
    check(stalls == 0, "R9 burst stalls", stalls, 0);
    drain("R9 burst drain");

    // R9: two words buffered with the core stalled -> not ready
    rmode = 3;
    configure(3, 128);
    send_word(32'h0BADBEEF, tries);
    send_word(32'h12345678, tries);
    stop_in();
    check(in_ready == 1'b0, "R9 ready low when full", in_ready, 0);
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R9 ready stays low", in_ready, 0);
    rmode = 0;
    drain("R9 stall drain");
    check(in_ready == 1'b1, "R9 ready back", in_ready, 1);

    done_all = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule